// File: doc/BRIEF.md
# Spilling Return Stack

This block is the return and status stack of a DSP sequencer. It keeps sixteen entries on chip in a circular buffer. When a push arrives while the buffer is full, the oldest on-chip entry is written out to a region of external data memory and the new entry takes its slot. Running out of on-chip space is therefore a recoverable event and not a fatal error. A pop that drains the last on-chip entry while spilled entries still exist fetches the most recently spilled entry back. Each memory transfer stalls the requester for exactly two clocks.

The region in memory starts at a programmable 24-bit base address. A programmable limit sets how many entries the region may hold. The memory interface is a single-port synchronous port. A request with the write flag stores the write data at the given address. A request without it returns read data in the following cycle.

The controller is a five-state machine. In ST_IDLE it accepts commands. A push onto a full buffer takes the SPILL transition to ST_SPILL_WR, which issues the write. ST_SPILL_WR always moves to ST_SPILL_WAIT, and ST_SPILL_WAIT always returns to ST_IDLE. A pop that empties the buffer while spilled entries remain takes the FILL transition to ST_FILL_RD, which issues the read. ST_FILL_RD always moves to ST_FILL_LD, which loads the returned word and returns to ST_IDLE. Every other accepted command, and every idle cycle, stays in ST_IDLE.

Top module: `hw_stack_spill`

## Requirements
- R1: After reset, busy_o, underflow_o, limit_err_o, mem_req_o and pop_data_o are all zero.
- R2: Up to 16 entries behave as a LIFO held on chip, with no memory request and busy_o staying low.
- R3: A push while 16 entries are on chip is accepted. In the next cycle exactly one write request (mem_we_o=1) carries the oldest on-chip entry, and busy_o is high for exactly two cycles starting in that cycle.
- R4: The first spill writes at spill_base_i. Each spill writes at base plus the number of entries already spilled, so successive spills use rising addresses. Each refill reads at base plus that count minus one, so successive refills use falling addresses. Every request lasts a single cycle.
- R5: A pop that leaves zero entries on chip while spilled entries exist issues one read request (mem_we_o=0) in the next cycle, and busy_o is high for two cycles. Afterwards one entry is on chip again, so every pushed value comes back in exact reverse order.
- R6: pop_data_o is registered. It takes the popped value in the cycle after an accepted pop and holds it in every other cycle.
- R7: A pop when neither on-chip nor spilled entries exist sets underflow_o, which stays set until reset. pop_data_o is left unchanged.
- R8: A push onto a full buffer when the spilled count already equals spill_limit_i is dropped. It sets limit_err_o, which stays set until reset, and causes no memory request and no stall.
- R9: push_i and pop_i are ignored in every cycle in which busy_o is high.
- R10: When push_i and pop_i are high together in an idle cycle, the push is performed and the pop is ignored.
- R11: Every memory request addresses the region [spill_base_i, spill_base_i + spill_limit_i).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Push command |
| pop_i | input | 1 | Pop command |
| push_data_i | input | 24 | Entry to push |
| spill_base_i | input | 24 | First address of the spill region (hold stable) |
| spill_limit_i | input | 24 | Number of entries the spill region holds (hold stable) |
| pop_data_o | output | 24 | Last popped entry |
| busy_o | output | 1 | Stall: commands are ignored while high |
| underflow_o | output | 1 | Sticky pop-on-empty flag |
| limit_err_o | output | 1 | Sticky spill-region-exhausted flag |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 24 | Memory address |
| mem_wdata_o | output | 24 | Memory write data |
| mem_rdata_i | input | 24 | Memory read data, valid the cycle after a read request |

## Verification
Several rules are checked on every cycle by the assertions:
- the two-cycle shape of each stall;
- one-cycle memory requests, which occur only while stalled;
- addresses that stay inside the spill region;
- the stickiness of both error flags;
- pop_data_o holding except after an accepted pop, which also covers commands during a stall and the push-plus-pop case.

Only the directed scenarios can show whether the data is right. They check that the evicted word is the oldest one and that spill addresses rise and refill addresses fall. They also check that a full round trip through memory returns the values in reverse order, and that ignored or dropped commands left the stack contents intact.

// File: rtl/hstk_pkg.sv
package hstk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SPILL_WR,
        ST_SPILL_WAIT,
        ST_FILL_RD,
        ST_FILL_LD
    } hstk_state_e;

endpackage

// File: rtl/hstk_ring.sv
// Circular on-chip store. The oldest entry sits at bot_q. A push onto a full
// ring overwrites the oldest slot and advances bot_q. DEPTH must be a power of two.
module hstk_ring #(
    parameter int DEPTH = 16,
    parameter int DW    = 24,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_en,
    input  logic          pop_en,
    input  logic          load_en,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] ldata,
    output logic [DW-1:0] top_o,
    output logic [DW-1:0] bot_o,
    output logic [CW-1:0] cnt_o,
    output logic          full_o,
    output logic          empty_o
);

    logic [DW-1:0] slot_q [DEPTH];
    logic [PW-1:0] bot_q;
    logic [CW-1:0] cnt_q;
    logic [PW-1:0] wr_idx;
    logic [PW-1:0] top_idx;

    assign wr_idx  = bot_q + cnt_q[PW-1:0];
    assign top_idx = wr_idx - PW'(1);
    assign full_o  = (cnt_q == CW'(DEPTH));
    assign empty_o = (cnt_q == '0);
    assign cnt_o   = cnt_q;
    assign top_o   = slot_q[top_idx];
    assign bot_o   = slot_q[bot_q];

    always_ff @(posedge clk) begin
        if (push_en) begin
            slot_q[wr_idx] <= wdata;
        end else if (load_en) begin
            slot_q[bot_q] <= ldata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bot_q <= '0;
            cnt_q <= '0;
        end else if (push_en) begin
            if (full_o) begin
                bot_q <= bot_q + PW'(1);
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end else if (pop_en) begin
            cnt_q <= cnt_q - CW'(1);
        end else if (load_en) begin
            cnt_q <= CW'(1);
        end
    end

endmodule

// File: rtl/hstk_ctl.sv
module hstk_ctl
    import hstk_pkg::*;
#(
    parameter int DW = 24,
    parameter int AW = 24,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [AW-1:0] spill_base_i,
    input  logic [AW-1:0] spill_limit_i,
    input  logic          full_i,
    input  logic          empty_i,
    input  logic [CW-1:0] cnt_i,
    input  logic [DW-1:0] top_i,
    input  logic [DW-1:0] bot_i,
    input  logic [DW-1:0] mem_rdata_i,
    output logic          ring_push_o,
    output logic          ring_pop_o,
    output logic          ring_load_o,
    output logic [DW-1:0] pop_data_o,
    output logic          busy_o,
    output logic          underflow_o,
    output logic          limit_err_o,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o
);

    hstk_state_e   state_q, state_d;
    logic [AW-1:0] spilled_q;
    logic [DW-1:0] evict_q;
    logic          idle;
    logic          take_push, room_out, do_push, lim_hit;
    logic          take_pop, do_pop, no_entry, need_fill, have_spill;

    assign idle       = (state_q == ST_IDLE);
    assign have_spill = (spilled_q != '0);
    assign room_out   = (spilled_q < spill_limit_i);
    assign take_push  = idle && push_i;
    assign do_push    = take_push && (!full_i || room_out);
    assign lim_hit    = take_push && full_i && !room_out;
    assign take_pop   = idle && pop_i && !push_i;
    assign do_pop     = take_pop && !empty_i;
    assign no_entry   = take_pop && empty_i && !have_spill;
    assign need_fill  = do_pop && (cnt_i == CW'(1)) && have_spill;

    assign ring_push_o = do_push;
    assign ring_pop_o  = do_pop;
    assign ring_load_o = (state_q == ST_FILL_LD);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (do_push && full_i) begin
                    state_d = ST_SPILL_WR;
                end else if (need_fill) begin
                    state_d = ST_FILL_RD;
                end
            end
            ST_SPILL_WR:   state_d = ST_SPILL_WAIT;
            ST_SPILL_WAIT: state_d = ST_IDLE;
            ST_FILL_RD:    state_d = ST_FILL_LD;
            ST_FILL_LD:    state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy_o      = 1'b1;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = spill_base_i + spilled_q;
        mem_wdata_o = evict_q;
        unique case (state_q)
            ST_IDLE:       busy_o = 1'b0;
            ST_SPILL_WR: begin
                mem_req_o = 1'b1;
                mem_we_o  = 1'b1;
            end
            ST_SPILL_WAIT: busy_o = 1'b1;
            ST_FILL_RD: begin
                mem_req_o  = 1'b1;
                mem_addr_o = spill_base_i + spilled_q - AW'(1);
            end
            ST_FILL_LD:    busy_o = 1'b1;
            default:       busy_o = 1'b1;
        endcase
    end

    // Data path registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spilled_q   <= '0;
            evict_q     <= '0;
            pop_data_o  <= '0;
            underflow_o <= 1'b0;
            limit_err_o <= 1'b0;
        end else begin
            if (do_push && full_i) begin
                evict_q <= bot_i;
            end
            if (state_q == ST_SPILL_WR) begin
                spilled_q <= spilled_q + AW'(1);
            end else if (state_q == ST_FILL_LD) begin
                spilled_q <= spilled_q - AW'(1);
            end
            if (do_pop) begin
                pop_data_o <= top_i;
            end
            if (no_entry) begin
                underflow_o <= 1'b1;
            end
            if (lim_hit) begin
                limit_err_o <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/hw_stack_spill.sv
module hw_stack_spill #(
    parameter int DEPTH = 16,
    parameter int DW    = 24,
    parameter int AW    = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [DW-1:0] push_data_i,
    input  logic [AW-1:0] spill_base_i,
    input  logic [AW-1:0] spill_limit_i,
    output logic [DW-1:0] pop_data_o,
    output logic          busy_o,
    output logic          underflow_o,
    output logic          limit_err_o,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic [DW-1:0] mem_rdata_i
);

    localparam int CW = $clog2(DEPTH) + 1;

    logic          ring_push, ring_pop, ring_load;
    logic [DW-1:0] ring_top, ring_bot;
    logic [CW-1:0] ring_cnt;
    logic          ring_full, ring_empty;

    hstk_ring #(
        .DEPTH (DEPTH),
        .DW    (DW)
    ) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_en (ring_push),
        .pop_en  (ring_pop),
        .load_en (ring_load),
        .wdata   (push_data_i),
        .ldata   (mem_rdata_i),
        .top_o   (ring_top),
        .bot_o   (ring_bot),
        .cnt_o   (ring_cnt),
        .full_o  (ring_full),
        .empty_o (ring_empty)
    );

    hstk_ctl #(
        .DW (DW),
        .AW (AW),
        .CW (CW)
    ) u_ctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .push_i        (push_i),
        .pop_i         (pop_i),
        .spill_base_i  (spill_base_i),
        .spill_limit_i (spill_limit_i),
        .full_i        (ring_full),
        .empty_i       (ring_empty),
        .cnt_i         (ring_cnt),
        .top_i         (ring_top),
        .bot_i         (ring_bot),
        .mem_rdata_i   (mem_rdata_i),
        .ring_push_o   (ring_push),
        .ring_pop_o    (ring_pop),
        .ring_load_o   (ring_load),
        .pop_data_o    (pop_data_o),
        .busy_o        (busy_o),
        .underflow_o   (underflow_o),
        .limit_err_o   (limit_err_o),
        .mem_req_o     (mem_req_o),
        .mem_we_o      (mem_we_o),
        .mem_addr_o    (mem_addr_o),
        .mem_wdata_o   (mem_wdata_o)
    );

endmodule

// File: rtl/hw_stack_spill_chk.sv
module hw_stack_spill_chk #(
    parameter int DW = 24,
    parameter int AW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          push_i,
    input logic          pop_i,
    input logic [AW-1:0] spill_base_i,
    input logic [AW-1:0] spill_limit_i,
    input logic [DW-1:0] pop_data_o,
    input logic          busy_o,
    input logic          underflow_o,
    input logic          limit_err_o,
    input logic          mem_req_o,
    input logic [AW-1:0] mem_addr_o
);

    assert_stall_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |=> busy_o)
        else $error("stall shorter than two cycles");

    assert_stall_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |=> !busy_o)
        else $error("stall longer than two cycles");

    assert_req_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> !mem_req_o)
        else $error("memory request held over two cycles");

    assert_req_stalled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> busy_o)
        else $error("memory request without stall");

    assert_in_region_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> ((mem_addr_o - spill_base_i) < spill_limit_i))
        else $error("memory address outside spill region");

    assert_uflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_o |=> underflow_o)
        else $error("underflow flag cleared");

    assert_limit_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        limit_err_o |=> limit_err_o)
        else $error("limit flag cleared");

    assert_pop_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_i |=> $stable(pop_data_o))
        else $error("pop data changed without pop");

    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(pop_data_o))
        else $error("pop accepted while busy");

    assert_push_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> $stable(pop_data_o))
        else $error("pop taken alongside push");

endmodule

bind hw_stack_spill hw_stack_spill_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .push_i        (push_i),
    .pop_i         (pop_i),
    .spill_base_i  (spill_base_i),
    .spill_limit_i (spill_limit_i),
    .pop_data_o    (pop_data_o),
    .busy_o        (busy_o),
    .underflow_o   (underflow_o),
    .limit_err_o   (limit_err_o),
    .mem_req_o     (mem_req_o),
    .mem_addr_o    (mem_addr_o)
);

// File: tb/tb_hw_stack_spill.sv
module tb_hw_stack_spill;

    localparam logic [23:0] BASE = 24'h000040;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_i = 1'b0;
    logic        pop_i = 1'b0;
    logic [23:0] push_data_i = '0;
    logic [23:0] spill_base_i = BASE;
    logic [23:0] spill_limit_i = 24'd32;
    logic [23:0] pop_data_o;
    logic        busy_o, underflow_o, limit_err_o;
    logic        mem_req_o, mem_we_o;
    logic [23:0] mem_addr_o, mem_wdata_o;
    logic [23:0] mem_rdata_i = '0;

    int tests = 0;
    int fails = 0;

    logic [23:0] exp_stk [0:63];
    int tot, on_c, sp_c;
    logic [23:0] bmem [0:255];

    hw_stack_spill dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .push_i        (push_i),
        .pop_i         (pop_i),
        .push_data_i   (push_data_i),
        .spill_base_i  (spill_base_i),
        .spill_limit_i (spill_limit_i),
        .pop_data_o    (pop_data_o),
        .busy_o        (busy_o),
        .underflow_o   (underflow_o),
        .limit_err_o   (limit_err_o),
        .mem_req_o     (mem_req_o),
        .mem_we_o      (mem_we_o),
        .mem_addr_o    (mem_addr_o),
        .mem_wdata_o   (mem_wdata_o),
        .mem_rdata_i   (mem_rdata_i)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (mem_req_o) begin
            if (mem_we_o) bmem[mem_addr_o[7:0]] <= mem_wdata_o;
            else          mem_rdata_i <= bmem[mem_addr_o[7:0]];
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        push_i = 1'b0;
        pop_i  = 1'b0;
        rst_n  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tot = 0; on_c = 0; sp_c = 0;
    endtask

    task automatic do_push(input logic [23:0] d);
        bit full, spill;
        full  = (on_c == 16);
        spill = full && (sp_c < int'(spill_limit_i));
        @(negedge clk);
        push_i = 1'b1; push_data_i = d;
        @(negedge clk);
        push_i = 1'b0;
        if (full && !spill) begin
            chk("R8 limit flag", limit_err_o, 1);
            chk("R8 no stall", busy_o, 0);
            chk("R8 no request", mem_req_o, 0);
        end else if (spill) begin
            chk("R3 write req", {mem_req_o, mem_we_o}, 2'b11);
            chk("R4 spill addr", mem_addr_o, BASE + sp_c);
            chk("R3 evicted oldest", mem_wdata_o, exp_stk[sp_c]);
            chk("R3 busy 1", busy_o, 1);
            exp_stk[tot] = d; tot++; sp_c++;
            @(negedge clk);
            chk("R3 busy 2", {busy_o, mem_req_o}, 2'b10);
            @(negedge clk);
            chk("R3 stall over", busy_o, 0);
        end else begin
            chk("R2 no stall", {busy_o, mem_req_o}, 2'b00);
            exp_stk[tot] = d; tot++; on_c++;
        end
    endtask

    task automatic do_pop();
        logic [23:0] prev;
        prev = pop_data_o;
        @(negedge clk);
        pop_i = 1'b1;
        @(negedge clk);
        pop_i = 1'b0;
        if (tot == 0) begin
            chk("R7 underflow", underflow_o, 1);
            chk("R7 data kept", pop_data_o, prev);
        end else begin
            tot--; on_c--;
            chk("R2 R6 pop data", pop_data_o, exp_stk[tot]);
            if (on_c == 0 && sp_c > 0) begin
                chk("R5 read req", {mem_req_o, mem_we_o, busy_o}, 3'b101);
                chk("R4 refill addr", mem_addr_o, BASE + sp_c - 1);
                @(negedge clk);
                chk("R5 busy 2", {busy_o, mem_req_o}, 2'b10);
                @(negedge clk);
                chk("R5 stall over", busy_o, 0);
                on_c = 1; sp_c--;
            end else begin
                chk("R2 pop no stall", {busy_o, mem_req_o}, 2'b00);
            end
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 reset outs", {busy_o, underflow_o, limit_err_o, mem_req_o}, 4'b0000);
        chk("R1 reset data", pop_data_o, 0);
    endtask

    task automatic t_lifo();
        do_reset();
        for (int i = 0; i < 10; i++) do_push(24'h100000 + 24'(i * 7));
        for (int i = 0; i < 10; i++) do_pop();
        repeat (3) @(negedge clk);
        chk("R6 data holds", pop_data_o, 24'h100000);
    endtask

    task automatic t_spill();
        do_reset();
        for (int i = 0; i < 21; i++) do_push(24'hA50000 + 24'(i));
        for (int i = 0; i < 21; i++) do_pop();
        chk("R5 all drained", tot, 0);
    endtask

    task automatic t_busy();
        logic [23:0] held;
        do_reset();
        for (int i = 0; i < 16; i++) do_push(24'h300000 + 24'(i));
        do_pop();
        do_push(24'h3000FF);
        held = pop_data_o;
        @(negedge clk);
        push_i = 1'b1; push_data_i = 24'h3000AA;
        @(negedge clk);
        exp_stk[tot] = 24'h3000AA; tot++; sp_c++;
        push_data_i = 24'h3BAD00; pop_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        push_i = 1'b0; pop_i = 1'b0;
        chk("R9 pop ignored", pop_data_o, held);
        chk("R9 idle again", busy_o, 0);
        for (int i = 0; i < 18; i++) do_pop();
        do_pop();
    endtask

    task automatic t_simul();
        do_reset();
        for (int i = 0; i < 3; i++) do_push(24'h500000 + 24'(i));
        @(negedge clk);
        push_i = 1'b1; pop_i = 1'b1; push_data_i = 24'h5000EE;
        @(negedge clk);
        push_i = 1'b0; pop_i = 1'b0;
        chk("R10 pop ignored", pop_data_o, 0);
        exp_stk[tot] = 24'h5000EE; tot++; on_c++;
        for (int i = 0; i < 4; i++) do_pop();
        chk("R10 no underflow", underflow_o, 0);
    endtask

    task automatic t_uflow();
        do_reset();
        do_pop();
        do_push(24'h777777);
        do_pop();
        chk("R7 sticky", underflow_o, 1);
    endtask

    task automatic t_limit();
        spill_limit_i = 24'd2;
        do_reset();
        for (int i = 0; i < 18; i++) do_push(24'h900000 + 24'(i));
        chk("R8 clear before", limit_err_o, 0);
        do_push(24'h9DEAD0);
        for (int i = 0; i < 18; i++) do_pop();
        chk("R8 sticky", limit_err_o, 1);
        spill_limit_i = 24'd32;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", tests, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_lifo();
        t_spill();
        t_busy();
        t_simul();
        t_uflow();
        t_limit();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule